// File: doc/BRIEF.md
# I/O Window Address Translator

This block compares each host I/O address against a bank of seven programmable windows. When an address falls inside an enabled window, it produces a card-side address and the access attributes for that cycle. Each window has a start bound, an end bound, an additive offset, a width policy and a timing-set choice. The bounds and the offset are all byte granular across a 64 KB I/O space.

The translation is combinational from the host address and the stored configuration. Only the configuration port is clocked. Software must never program overlapping windows. If it does, the block still resolves the cycle to the lowest-numbered matching window and raises an error flag alongside the result.

Access width works in one of two ways:
- In automatic mode, the width follows the card's active-low 16-bit I/O signal.
- A forced 8-bit or 16-bit setting overrides that signal.

The selected timing set (0 or 1) is only reported on an output. It names the register set that governs setup, command and recovery times, which are counted elsewhere.

Top module: `iowin_xlate`

## Requirements
- R1: After reset every window is disabled, so `hit` is 0 for every host address until a control write sets an enable bit.
- R2: A window matches when its enable bit is 1 and start ≤ `host_addr` ≤ end, with both bounds inclusive. `hit` is 1 exactly when at least one window matches.
- R3: On a hit, `card_addr` equals `host_addr` plus the selected window's offset, modulo 65536.
- R4: Control field bits [2:1] set the width policy. Codes 00 and 11 select automatic mode, where `wide16` = NOT `card_io16_n`. Code 01 forces 8-bit (`wide16`=0), and code 10 forces 16-bit (`wide16`=1).
- R5: On a hit, `tset` equals control bit [3] of the selected window.
- R6: When several windows match, `win_idx` is the lowest matching index and `overlap_err` is 1. `overlap_err` is 1 only when two or more windows match.
- R7: A configuration write is accepted on a rising clock edge and is visible from the next cycle onward.
  - `cfg_sel` encodes the field: 0 = start, 1 = end, 2 = offset, 3 = control.
  - Control bit [0] is the enable.
  - A write whose `cfg_win` is 7 changes nothing.
- R8: With no hit, `win_idx`, `card_addr`, `wide16`, `tset` and `overlap_err` are all 0.
- R9: An enabled window whose start is greater than its end matches no address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration registers |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_win | input | 3 | Window index of the write (0 to 6; 7 is ignored) |
| cfg_sel | input | 2 | Field select: 0 start, 1 end, 2 offset, 3 control |
| cfg_wdata | input | 16 | Write data |
| host_addr | input | 16 | Host I/O address being decoded |
| card_io16_n | input | 1 | Card's active-low 16-bit I/O indication |
| hit | output | 1 | Address lies in an enabled window |
| win_idx | output | 3 | Index of the selected window |
| card_addr | output | 16 | Translated card address |
| wide16 | output | 1 | 1 = 16-bit access, 0 = 8-bit access |
| tset | output | 1 | Timing register set for the access |
| overlap_err | output | 1 | More than one window matched |

## Verification
The bench first uses a fixed layout of windows: one with automatic width, one whose offset wraps past 64 KB, one forced to 16-bit, one with inverted bounds, and one that overlaps a lower window. It probes each bound and each address just outside it, which separates inclusive from exclusive comparison and priority from overlap detection. Toggling the card's 16-bit signal on the same addresses separates automatic width from the forced modes. A long run of random writes and near-boundary addresses then checks the next-cycle visibility of configuration writes and the ignored index 7. Every output is compared against the behavioural model on every clock.

// File: rtl/iowin_pkg.sv
package iowin_pkg;
    localparam int IOW_ADDR_W = 16;
    localparam int IOW_NUM    = 7;

    typedef enum logic [1:0] {
        FLD_START = 2'd0,
        FLD_END   = 2'd1,
        FLD_OFS   = 2'd2,
        FLD_CTRL  = 2'd3
    } cfg_field_e;

    localparam logic [1:0] WM_AUTO  = 2'b00;
    localparam logic [1:0] WM_FORCE8  = 2'b01;
    localparam logic [1:0] WM_FORCE16 = 2'b10;
endpackage

// File: rtl/iowin_regs.sv
module iowin_regs
    import iowin_pkg::*;
#(
    parameter int NUM_WIN = IOW_NUM,
    parameter int ADDR_W  = IOW_ADDR_W,
    localparam int IDX_W  = $clog2(NUM_WIN + 1)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             we,
    input  logic [IDX_W-1:0]                 win,
    input  logic [1:0]                       sel,
    input  logic [ADDR_W-1:0]                wdata,
    output logic [NUM_WIN-1:0]               en,
    output logic [NUM_WIN-1:0][ADDR_W-1:0]   lo,
    output logic [NUM_WIN-1:0][ADDR_W-1:0]   hi,
    output logic [NUM_WIN-1:0][ADDR_W-1:0]   ofs,
    output logic [NUM_WIN-1:0][1:0]          wmode,
    output logic [NUM_WIN-1:0]               tsel
);
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        logic wr_here;
        assign wr_here = we && (win == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                en[g]    <= 1'b0;
                lo[g]    <= '0;
                hi[g]    <= '0;
                ofs[g]   <= '0;
                wmode[g] <= WM_AUTO;
                tsel[g]  <= 1'b0;
            end else if (wr_here) begin
                unique case (cfg_field_e'(sel))
                    FLD_START: lo[g]  <= wdata;
                    FLD_END:   hi[g]  <= wdata;
                    FLD_OFS:   ofs[g] <= wdata;
                    FLD_CTRL: begin
                        en[g]    <= wdata[0];
                        wmode[g] <= wdata[2:1];
                        tsel[g]  <= wdata[3];
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/iowin_match.sv
module iowin_match
    import iowin_pkg::*;
#(
    parameter int NUM_WIN = IOW_NUM,
    parameter int ADDR_W  = IOW_ADDR_W
) (
    input  logic [ADDR_W-1:0]               addr,
    input  logic [NUM_WIN-1:0]              en,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0]  lo,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0]  hi,
    output logic [NUM_WIN-1:0]              match
);
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
        assign match[g] = en[g] && (addr >= lo[g]) && (addr <= hi[g]);
    end
endmodule

// File: rtl/iowin_select.sv
module iowin_select
    import iowin_pkg::*;
#(
    parameter int NUM_WIN = IOW_NUM,
    parameter int ADDR_W  = IOW_ADDR_W,
    localparam int IDX_W  = $clog2(NUM_WIN + 1)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [ADDR_W-1:0]               addr,
    input  logic                            io16_n,
    input  logic [NUM_WIN-1:0]              match,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0]  ofs,
    input  logic [NUM_WIN-1:0][1:0]         wmode,
    input  logic [NUM_WIN-1:0]              tsel,
    output logic                            hit,
    output logic [IDX_W-1:0]                idx,
    output logic [ADDR_W-1:0]               card_addr,
    output logic                            wide16,
    output logic                            tset,
    output logic                            overlap
);
    logic [IDX_W:0] n_match;
    logic [1:0]     mode_sel;

    always_comb begin
        idx     = '0;
        n_match = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (match[i]) begin
                idx     = IDX_W'(i);
                n_match = n_match + (IDX_W+1)'(1);
            end
        end
    end

    assign hit      = |match;
    assign overlap  = (n_match > (IDX_W+1)'(1));
    assign mode_sel = wmode[idx];

    always_comb begin
        card_addr = '0;
        wide16    = 1'b0;
        tset      = 1'b0;
        if (hit) begin
            card_addr = addr + ofs[idx];
            tset      = tsel[idx];
            unique case (mode_sel)
                WM_FORCE8:  wide16 = 1'b0;
                WM_FORCE16: wide16 = 1'b1;
                default:    wide16 = ~io16_n;
            endcase
        end
    end

    // R8
    no_hit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (idx == '0 && card_addr == '0 && !wide16 && !tset && !overlap));
    // R6
    overlap_count_chk: assert property (@(posedge clk) disable iff (rst)
        overlap |-> ($countones(match) >= 2));
    // R2
    single_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && !overlap) |-> ($countones(match) == 1 && match[idx]));
endmodule

// File: rtl/iowin_xlate.sv
module iowin_xlate
    import iowin_pkg::*;
#(
    parameter int NUM_WIN = IOW_NUM,
    parameter int ADDR_W  = IOW_ADDR_W,
    localparam int IDX_W  = $clog2(NUM_WIN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_win,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              card_io16_n,
    output logic              hit,
    output logic [IDX_W-1:0]  win_idx,
    output logic [ADDR_W-1:0] card_addr,
    output logic              wide16,
    output logic              tset,
    output logic              overlap_err
);
    logic [NUM_WIN-1:0]             w_en;
    logic [NUM_WIN-1:0][ADDR_W-1:0] w_lo;
    logic [NUM_WIN-1:0][ADDR_W-1:0] w_hi;
    logic [NUM_WIN-1:0][ADDR_W-1:0] w_ofs;
    logic [NUM_WIN-1:0][1:0]        w_mode;
    logic [NUM_WIN-1:0]             w_tsel;
    logic [NUM_WIN-1:0]             w_match;

    iowin_regs #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .win(cfg_win), .sel(cfg_sel),
        .wdata(cfg_wdata), .en(w_en), .lo(w_lo), .hi(w_hi), .ofs(w_ofs),
        .wmode(w_mode), .tsel(w_tsel)
    );

    iowin_match #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W)) u_match (
        .addr(host_addr), .en(w_en), .lo(w_lo), .hi(w_hi), .match(w_match)
    );

    iowin_select #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W)) u_sel (
        .clk(clk), .rst(rst), .addr(host_addr), .io16_n(card_io16_n),
        .match(w_match), .ofs(w_ofs), .wmode(w_mode), .tsel(w_tsel),
        .hit(hit), .idx(win_idx), .card_addr(card_addr), .wide16(wide16),
        .tset(tset), .overlap(overlap_err)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !hit);
    // R7
    disable_write_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == FLD_CTRL && !cfg_wdata[0] && cfg_win < IDX_W'(NUM_WIN))
        |=> !(hit && win_idx == $past(cfg_win)));
endmodule

// File: tb/iowin_xlate_bench.sv
`timescale 1ns/1ps
module iowin_xlate_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_win = '0;
    logic [1:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] host_addr = '0;
    logic        card_io16_n = 1'b1;
    logic        hit, wide16, tset, overlap_err;
    logic [2:0]  win_idx;
    logic [15:0] card_addr;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // behavioural model of the window bank
    bit          m_en  [7];
    int          m_lo  [7];
    int          m_hi  [7];
    int          m_ofs [7];
    int          m_mode[7];
    bit          m_ts  [7];

    always #5 clk = ~clk;

    iowin_xlate u_iowin_xlate (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_win(cfg_win),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .host_addr(host_addr),
        .card_io16_n(card_io16_n), .hit(hit), .win_idx(win_idx),
        .card_addr(card_addr), .wide16(wide16), .tset(tset),
        .overlap_err(overlap_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 7; i++) begin
            m_en[i] = 0; m_lo[i] = 0; m_hi[i] = 0;
            m_ofs[i] = 0; m_mode[i] = 0; m_ts[i] = 0;
        end
    endtask

    task automatic compare_all();
        bit e_hit = 0;
        int e_idx = 0, cnt = 0, e_card = 0, e_w = 0, e_t = 0;
        int a = int'(host_addr);
        for (int i = 0; i < 7; i++) begin
            if (m_en[i] && a >= m_lo[i] && a <= m_hi[i]) begin
                if (!e_hit) e_idx = i;
                e_hit = 1;
                cnt++;
            end
        end
        if (e_hit) begin
            e_card = (a + m_ofs[e_idx]) % 65536;
            e_t    = int'(m_ts[e_idx]);
            if (m_mode[e_idx] == 1)      e_w = 0;
            else if (m_mode[e_idx] == 2) e_w = 1;
            else                         e_w = int'(!card_io16_n);
        end
        chk("R2 hit",         int'(hit),         int'(e_hit));
        chk("R6 win_idx",     int'(win_idx),     e_idx);
        chk("R3 card_addr",   int'(card_addr),   e_card);
        chk("R4 wide16",      int'(wide16),      e_w);
        chk("R5 tset",        int'(tset),        e_t);
        chk("R6 overlap_err", int'(overlap_err), int'(cnt > 1));
    endtask

    // one cycle: compare current outputs, drive new inputs, clock, update model
    task automatic step(input bit we, input int w, input int f, input int d,
                        input int a, input bit io_n);
        compare_all();
        cfg_we = we; cfg_win = 3'(w); cfg_sel = 2'(f); cfg_wdata = 16'(d);
        host_addr = 16'(a); card_io16_n = io_n;
        @(posedge clk);
        if (we && w < 7) begin
            case (f)
                0: m_lo[w]  = d % 65536;
                1: m_hi[w]  = d % 65536;
                2: m_ofs[w] = d % 65536;
                default: begin
                    m_en[w]   = d[0];
                    m_mode[w] = (d >> 1) & 3;
                    m_ts[w]   = d[3];
                end
            endcase
        end
        @(negedge clk);
    endtask

    task automatic prog(input int w, input int lo, input int hi, input int ofs,
                        input int ctrl);
        step(1, w, 0, lo, 0, 1);
        step(1, w, 1, hi, 0, 1);
        step(1, w, 2, ofs, 0, 1);
        step(1, w, 3, ctrl, 0, 1);
    endtask

    task automatic probe(input int a);
        step(0, 0, 0, 0, a, 1);
        step(0, 0, 0, 0, a, 0);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: all disabled after reset
        host_addr = 16'h0000; #1;
        chk("R1 hit after reset @0000", int'(hit), 0);
        host_addr = 16'hFFFF; #1;
        chk("R1 hit after reset @FFFF", int'(hit), 0);
        @(negedge clk);

        // fixed layout
        prog(0, 16'h0100, 16'h01FF, 16'h1000, 16'h0001);        // auto, t0
        prog(1, 16'h0300, 16'h0307, 16'hFF00, 16'h000B);        // force8, t1, wraps
        prog(2, 16'h0400, 16'h040F, 16'h0000, 16'h0005);        // force16
        prog(3, 16'h0600, 16'h05FF, 16'h0010, 16'h0001);        // inverted bounds
        prog(4, 16'h0180, 16'h0280, 16'h0002, 16'h000F);        // overlaps w0, mode 11
        foreach (m_en[i]) begin end
        for (int k = 0; k < 5; k++) begin
            int b[5] = '{16'h0100, 16'h0300, 16'h0400, 16'h0180, 16'h0600};
            int e[5] = '{16'h01FF, 16'h0307, 16'h040F, 16'h0280, 16'h05FF};
            probe(b[k] - 1); probe(b[k]); probe(b[k] + 1);
            probe(e[k] - 1); probe(e[k]); probe(e[k] + 1);
        end

        // R9: inverted window at its own start address
        step(0, 0, 0, 0, 16'h0600, 1);
        chk("R9 inverted bounds hit", int'(hit), 0);
        // R3: wrap of card address
        step(0, 0, 0, 0, 16'h0305, 1);
        chk("R3 wrapped card_addr", int'(card_addr), 16'h0205);
        // R6: priority in overlap region
        step(0, 0, 0, 0, 16'h01C0, 1);
        chk("R6 lowest index wins", int'(win_idx), 0);
        chk("R6 overlap flagged", int'(overlap_err), 1);
        // R4: forced 16 regardless of card signal
        step(0, 0, 0, 0, 16'h0404, 1);
        chk("R4 forced 16-bit", int'(wide16), 1);

        // R7: write to index 7 changes nothing
        step(1, 7, 0, 16'h0000, 16'h0900, 1);
        step(1, 7, 1, 16'hFFFF, 16'h0900, 1);
        step(1, 7, 3, 16'h0001, 16'h0900, 1);
        step(0, 0, 0, 0, 16'h0900, 1);
        chk("R7 index 7 ignored", int'(hit), 0);
        // R7: enable visible exactly one cycle after the write
        step(1, 5, 0, 16'h0900, 16'h0900, 1);
        step(1, 5, 1, 16'h0900, 16'h0900, 1);
        step(1, 5, 3, 16'h0001, 16'h0900, 1);
        chk("R7 write visible next cycle", int'(hit), 1);
        chk("R7 window index", int'(win_idx), 5);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            int r = int'($urandom_range(0, 9));
            int w = int'($urandom_range(0, 7));
            int a;
            if (r < 2) begin
                step(1, w, int'($urandom_range(0, 3)), int'($urandom_range(0, 65535)),
                     int'($urandom_range(0, 65535)), bit'($urandom_range(0, 1)));
            end else begin
                int v = (w < 7) ? ((r & 1) ? m_lo[w] : m_hi[w]) : int'($urandom_range(0, 65535));
                a = (v + int'($urandom_range(0, 2)) + 65535) % 65536;
                step(0, 0, 0, 0, a, bit'($urandom_range(0, 1)));
            end
        end
        compare_all();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule